// File: doc/BRIEF.md
# Dual Parallel Port with Timer-Driven Pins

This block holds the register state and pad logic for two 8-bit parallel ports, called port A and port B. Each port has a data-out register and a direction register. Both are written over a small register bus and can be read back on it. Port A drives its pins open-drain: it can only pull a pin low, and a pull-up supplies the high level. Port B drives its pins push-pull, with a separate output-enable and output-value per pin. Every pad input is sampled once per clock. A read of a data register returns that sampled pad level, not the stored latch value.

The top bits of port B can be taken over by external timers. A takeover control bit forces the pin to be an output and routes the timer's pulse or toggle level onto it. This ignores the direction register. The timers, the address decoding and the analog drivers sit outside the block: the takeover bits and timer levels arrive as inputs.

Stored values reach the pads through a second hold register that loads one cycle after the write. A write in progress therefore never disturbs the pads in its own cycle.

Top module: `pio_port_pair`

## Requirements
- R1: While reset is asserted and after it is released, both direction registers and both data-out registers read as zero. `pa_pd`, `pb_oe` and `pb_out` are all zero.
- R2: A direction bit of 1 makes its pin an output. A 0 makes it an input with the driver off: the pull-down is off on port A, and the output-enable is low on port B.
- R3: Reading a data register returns the pad level captured at the previous clock edge, never the stored latch. Reading a direction register returns the stored value.
- R4: Register select `addr` uses this map: 0 is port A data, 1 is port B data, 2 is port A direction, 3 is port B direction. A write takes effect at the clock edge where `wr_en` is high.
- R5: Pad outputs change at the clock edge after the edge that stores a write. During the write's own cycle they keep their previous values.
- R6: Port A asserts pull-down enable `pa_pd[i]` exactly when its direction bit is 1 and its data bit is 0.
- R7: On port B pins that are not taken over, `pb_oe` equals the direction bit and `pb_out` equals the data bit.
- R8: Takeover bit `ovr_en[0]` forces pin 6 of port B to drive `tmr_out[0]`. Takeover bit `ovr_en[1]` forces pin 7 to drive `tmr_out[1]`. In both cases `pb_oe` is forced high whatever the direction bit holds.
- R9: On a taken-over pin, `pb_out` follows the timer level combinationally, within the same cycle.
- R10: A read-modify-write on port A data while an external source holds an output pin low stores a 0 for that pin. The pin then stays low after the external source lets go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational on `addr`) |
| pa_in | input | 8 | Port A pad levels |
| pa_pd | output | 8 | Port A pull-down enables |
| pb_in | input | 8 | Port B pad levels |
| pb_oe | output | 8 | Port B output enables |
| pb_out | output | 8 | Port B output values |
| ovr_en | input | 2 | Timer takeover bits (bit 0 controls pin 6, bit 1 controls pin 7) |
| tmr_out | input | 2 | Timer output levels (bit 0 for pin 6, bit 1 for pin 7) |

## Verification
The bench builds the block with its defaults: an 8-bit width and two taken-over pins. This puts a plain pin and both timer-driven pins side by side in every vector. Wired models of the pads sit in front of the block. An open-drain node with an external pull-down feeds port A, and a tri-state resolver feeds port B. With these models, the read-back of the pad level, the held-low read-modify-write and the precedence of a takeover over the direction bit can all be seen at the ports.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned N_REGS = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A_DATA = 2'd0,
    SEL_B_DATA = 2'd1,
    SEL_A_DIR  = 2'd2,
    SEL_B_DIR  = 2'd3
  } pio_sel_e;

  // open-drain pin: pull low only when output and data is 0
  function automatic logic od_pull(input logic dir, input logic dat);
    return dir & ~dat;
  endfunction

  // push-pull pin, optional timer takeover: returns {oe, value}
  function automatic logic [1:0] pp_drive(input logic dir, input logic dat,
                                          input logic take, input logic tmr);
    logic oe;
    logic val;
    oe  = dir | take;
    val = take ? tmr : dat;
    return {oe, val};
  endfunction
endpackage

// File: rtl/pio_store.sv
module pio_store #(
  parameter int unsigned W   = 8,
  parameter int unsigned SEL = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [pio_pkg::ADDR_W-1:0] addr,
  input  logic [W-1:0]               wr_data,
  output logic [W-1:0]               stored,
  output logic [W-1:0]               held
);
  logic hit;
  assign hit = wr_en && (addr == pio_pkg::ADDR_W'(SEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stored <= '0;
    else if (hit) stored <= wr_data;
  end

  // hold stage: pads see the value one cycle after the write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= stored;
  end
endmodule

// File: rtl/pio_pad_drive.sv
module pio_pad_drive #(
  parameter int unsigned W     = 8,
  parameter int unsigned N_OVR = 2
) (
  input  logic [W-1:0]     a_dat,
  input  logic [W-1:0]     a_dir,
  input  logic [W-1:0]     b_dat,
  input  logic [W-1:0]     b_dir,
  input  logic [N_OVR-1:0] ovr_en,
  input  logic [N_OVR-1:0] tmr_out,
  output logic [W-1:0]     pa_pd,
  output logic [W-1:0]     pb_oe,
  output logic [W-1:0]     pb_out
);
  import pio_pkg::*;
  localparam int unsigned OVR_BASE = W - N_OVR;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pa_pd[i] = od_pull(a_dir[i], a_dat[i]);
    if (i >= OVR_BASE) begin : g_take
      logic [1:0] drv;
      assign drv       = pp_drive(b_dir[i], b_dat[i], ovr_en[i-OVR_BASE], tmr_out[i-OVR_BASE]);
      assign pb_oe[i]  = drv[1];
      assign pb_out[i] = drv[0];
    end else begin : g_plain
      logic [1:0] drv;
      assign drv       = pp_drive(b_dir[i], b_dat[i], 1'b0, 1'b0);
      assign pb_oe[i]  = drv[1];
      assign pb_out[i] = drv[0];
    end
  end
endmodule

// File: rtl/pio_sampler.sv
module pio_sampler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pa_s,
  output logic [W-1:0] pb_s
);
  always_ff @(posedge clk) begin
    pa_s <= pa_in;
    pb_s <= pb_in;
  end
endmodule

// File: rtl/pio_port_pair.sv
module pio_port_pair #(
  parameter int unsigned W     = 8,
  parameter int unsigned N_OVR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  input  logic [W-1:0]     pa_in,
  output logic [W-1:0]     pa_pd,
  input  logic [W-1:0]     pb_in,
  output logic [W-1:0]     pb_oe,
  output logic [W-1:0]     pb_out,
  input  logic [N_OVR-1:0] ovr_en,
  input  logic [N_OVR-1:0] tmr_out
);
  import pio_pkg::*;

  logic [W-1:0] stored [N_REGS];
  logic [W-1:0] held   [N_REGS];
  logic [W-1:0] pa_s, pb_s;

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    pio_store #(.W(W), .SEL(k)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .stored(stored[k]), .held(held[k])
    );
  end

  pio_pad_drive #(.W(W), .N_OVR(N_OVR)) u_drive (
    .a_dat(held[SEL_A_DATA]), .a_dir(held[SEL_A_DIR]),
    .b_dat(held[SEL_B_DATA]), .b_dir(held[SEL_B_DIR]),
    .ovr_en(ovr_en), .tmr_out(tmr_out),
    .pa_pd(pa_pd), .pb_oe(pb_oe), .pb_out(pb_out)
  );

  pio_sampler #(.W(W)) u_samp (
    .clk(clk), .pa_in(pa_in), .pb_in(pb_in), .pa_s(pa_s), .pb_s(pb_s)
  );

  always_comb begin
    case (pio_sel_e'(addr))
      SEL_A_DATA: rd_data = pa_s;
      SEL_B_DATA: rd_data = pb_s;
      SEL_A_DIR:  rd_data = stored[SEL_A_DIR];
      default:    rd_data = stored[SEL_B_DIR];
    endcase
  end
endmodule

// File: rtl/pio_port_pair_chk.sv
module pio_port_pair_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned N_OVR = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [W-1:0]     wr_data,
  input logic [W-1:0]     rd_data,
  input logic [W-1:0]     pa_in,
  input logic [W-1:0]     pa_pd,
  input logic [W-1:0]     pb_oe,
  input logic [W-1:0]     pb_out,
  input logic [N_OVR-1:0] ovr_en,
  input logic [N_OVR-1:0] tmr_out
);
  localparam int unsigned OVR_BASE = W - N_OVR;

  // R1: pads released while reset holds
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_released: assert (pa_pd == '0 && pb_oe == '0 && pb_out == '0)
        else $error("pads driven during reset");
    end
  end

  // R5: a data-A write alone leaves the pull-downs unchanged in its own cycle
  a_r5_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !$past(wr_en)) |=> $stable(pa_pd));

  // R3: data-A read shows the pad level from the previous edge
  a_r3_pad_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rd_data == $past(pa_in)));

  // R3: direction read-back returns what was written
  a_r3_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (addr != 2'd2 || rd_data == $past(wr_data)));

  for (genvar j = 0; j < N_OVR; j++) begin : g_ovr
    // R8: takeover forces the driver on
    a_r8_take_oe: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en[j] |-> pb_oe[OVR_BASE+j]);
    // R9: takeover value follows the timer level
    a_r9_take_val: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en[j] |-> (pb_out[OVR_BASE+j] == tmr_out[j]));
  end
endmodule

bind pio_port_pair pio_port_pair_chk #(.W(W), .N_OVR(N_OVR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .pa_in(pa_in), .pa_pd(pa_pd), .pb_oe(pb_oe),
  .pb_out(pb_out), .ovr_en(ovr_en), .tmr_out(tmr_out)
);

// File: tb/pio_port_pair_test.sv
`timescale 1ns/1ps
module pio_port_pair_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, pa_in, pa_pd, pb_in, pb_oe, pb_out;
  logic [1:0] ovr_en = 0, tmr_out = 0;
  logic [7:0] a_ext = 0;   // bits held low by an outside source
  logic [7:0] b_ext = 0;   // levels an outside source presents on undriven B pins
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  // wired pad models
  assign pa_in = ~(pa_pd | a_ext);
  assign pb_in = (pb_oe & pb_out) | (~pb_oe & b_ext);

  pio_port_pair uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pa_in(pa_in), .pa_pd(pa_pd), .pb_in(pb_in),
    .pb_oe(pb_oe), .pb_out(pb_out), .ovr_en(ovr_en), .tmr_out(tmr_out)
  );

  typedef struct packed {
    logic [7:0] a_dir, a_dat, b_dir, b_dat;
    logic [1:0] ovr, tmr;
    logic [7:0] a_x, b_x;
    logic [7:0] e_pd, e_ard, e_oe, e_out, e_brd;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'hFF, 8'h0F, 8'hFF, 8'hA5, 2'b00, 2'b00, 8'h00, 8'h00, 8'hF0, 8'h0F, 8'hFF, 8'hA5, 8'hA5},
    '{8'h00, 8'h00, 8'h00, 8'hFF, 2'b00, 2'b00, 8'h3C, 8'h5A, 8'h00, 8'hC3, 8'h00, 8'hFF, 8'h5A},
    '{8'hF0, 8'h50, 8'h00, 8'h00, 2'b11, 2'b10, 8'h00, 8'h0F, 8'hA0, 8'h5F, 8'hC0, 8'h80, 8'h8F},
    '{8'hFF, 8'hFF, 8'h80, 8'h00, 2'b01, 2'b11, 8'h81, 8'hFF, 8'h00, 8'h7E, 8'hC0, 8'h40, 8'h7F}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rd_data;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: outputs released during reset
    check("R1 pa_pd in reset", pa_pd, 8'h00);
    check("R1 pb_oe in reset", pb_oe, 8'h00);
    rst_n = 1;
    settle();
    check("R1 pb_out after reset", pb_out, 8'h00);
    rd(2'd2, v); check("R1 A dir after reset", v, 8'h00);
    rd(2'd3, v); check("R1 B dir after reset", v, 8'h00);
    rd(2'd0, v); check("R2 A floats high as input", v, 8'hFF);
    rd(2'd1, v); check("R2 B undriven reads outside level", v, 8'h00);

    // vector table: R2 R3 R4 R6 R7 R8
    for (int k = 0; k < 4; k++) begin
      wr(2'd2, VECS[k].a_dir);
      wr(2'd0, VECS[k].a_dat);
      wr(2'd3, VECS[k].b_dir);
      wr(2'd1, VECS[k].b_dat);
      a_ext = VECS[k].a_x; b_ext = VECS[k].b_x;
      ovr_en = VECS[k].ovr; tmr_out = VECS[k].tmr;
      settle();
      check($sformatf("R6 vec%0d pa_pd", k), pa_pd, VECS[k].e_pd);
      check($sformatf("R7/R8 vec%0d pb_oe", k), pb_oe, VECS[k].e_oe);
      check($sformatf("R7/R8 vec%0d pb_out", k), pb_out, VECS[k].e_out);
      rd(2'd0, v); check($sformatf("R3 vec%0d A data read", k), v, VECS[k].e_ard);
      rd(2'd1, v); check($sformatf("R3 vec%0d B data read", k), v, VECS[k].e_brd);
      rd(2'd2, v); check($sformatf("R4 vec%0d A dir read", k), v, VECS[k].a_dir);
      rd(2'd3, v); check($sformatf("R4 vec%0d B dir read", k), v, VECS[k].b_dir);
    end

    // R5: pads hold during the write, change one edge later
    ovr_en = 0; a_ext = 0; b_ext = 0;
    wr(2'd0, 8'h00);            // A dir still FF from vec3
    check("R5 pa_pd held after write edge", pa_pd, 8'h00);
    @(negedge clk);
    check("R5 pa_pd updated next edge", pa_pd, 8'hFF);

    // R9: takeover follows timer level in the same cycle, direction 0
    wr(2'd3, 8'h00); settle();
    ovr_en = 2'b10; tmr_out = 2'b00;
    #1 check("R9 pin7 low with timer", pb_out & 8'h80, 8'h00);
    tmr_out = 2'b10;
    #1 check("R9 pin7 follows timer", pb_out & 8'h80, 8'h80);
    check("R8 pin7 driven despite dir 0", pb_oe, 8'h80);
    ovr_en = 0;
    #1 check("R7 takeover off releases pin", pb_oe, 8'h00);

    // R10: read-modify-write while bit 2 is held low outside
    wr(2'd0, 8'hFF); settle();
    a_ext = 8'h04; settle();
    rd(2'd0, v); check("R10 read sees held pin", v, 8'hFB);
    wr(2'd0, v | 8'h01); settle();
    a_ext = 8'h00; settle();
    rd(2'd0, v); check("R10 pin stays low after release", v, 8'hFB);
    check("R10 pull-down on bit 2", pa_pd, 8'h04);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule